// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Monitor

This block compares two pulse trains per channel: a reference strobe and a divided-feedback strobe. Both are one oscillator cycle wide and sampled on the oscillator clock. Each channel holds a tri-state comparator state machine. The machine records which strobe arrived first and drives a pump-control output until the other strobe arrives. A per-channel polarity bit flips the drive sense. High impedance is modelled as a drive-enable output and a separate drive-value output.

While a pulse is open, a counter clocked by the oscillator measures the error width in clock cycles. A second state machine per channel turns these widths into a lock flag. Lock is gained slowly, after several narrow comparisons in a row, and is lost at once. The two lock flags are merged into one lock output, and a channel in power-save counts as good. A selector routes either the merged lock or any one of the four input strobes to a single monitor output. Taking power-save away starts a quiet restart: the first reference strobe is used only to realign the comparator and produces no drive.

Comparator states: `PD_IDLE`, `PD_LEAD` (reference ahead), `PD_LAG` (feedback ahead), `PD_HOLD` (power-save or restart). Transitions:
- IDLE→LEAD on a reference strobe alone.
- IDLE→LAG on a feedback strobe alone.
- IDLE→IDLE on both strobes together, which is a completed comparison of width 0.
- LEAD→IDLE on a feedback strobe, and LAG→IDLE on a reference strobe. Each completes a comparison.
- any→HOLD while power-save is high.
- HOLD→IDLE on the first reference strobe after power-save falls.

Lock states: `LK_OFF`, `LK_ACQ` (counting good comparisons), `LK_ON`. Transitions:
- OFF/ACQ→ACQ on a good completion.
- ACQ→ON on the third consecutive good completion.
- OFF/ACQ→OFF on a wide completion.
- ON→OFF as soon as the open error reaches the drop width.
- any→OFF under power-save.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is low, both pump enables are 0 and the merged lock output is 0 when neither channel is in power-save.
- R2: Width is counted in clock edges, from the edge that samples the leading strobe to the edge that samples the trailing one. After a reference strobe alone, pump enable is 1 from the next cycle until the cycle after the feedback strobe is sampled. After a feedback strobe alone, the same holds with the roles swapped. With polarity bit 1, the drive value is 1 while the reference leads and 0 while it lags.
- R3: With polarity bit 0, the drive value is 0 while the reference leads and 1 while it lags. The drive value is 0 whenever enable is 0.
- R4: Both strobes sampled on the same edge complete a comparison of width 0 without enabling the pump. Extra strobes from the side that already leads keep the pulse open.
- R5: An unlocked channel becomes locked on the edge of the third consecutive completed comparison whose width is at most 4 (LOCK_W). A width of exactly 4 counts as good.
- R6: A locked channel drops lock on the edge at which its open error width has already reached 2 (UNLOCK_W), whether or not the pulse closes on that edge. A completion on that same edge is not counted. A completion after the drop is counted normally.
- R7: While acquiring, a completed width above 4 clears the good-comparison count.
- R8: The merged lock output is 1 only when each channel is locked or has power-save high.
- R9: Monitor select {lds,t1,t2}:
  - lds=0 routes the merged lock.
  - 1,0,0 routes reference 0.
  - 1,1,0 routes reference 1.
  - 1,0,1 routes feedback 0.
  - 1,1,1 routes feedback 1.
- R10: Power-save high forces that channel's pump enable to 0 in the same cycle and clears its lock state.
- R11: After power-save falls, feedback strobes are ignored and the pump stays disabled until the first reference strobe. That strobe starts no comparison. The next strobe starts a normal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 2 | Reference strobe per channel |
| div_pulse | input | 2 | Divided-feedback strobe per channel |
| pol | input | 2 | Pump polarity per channel |
| psave | input | 2 | Power-save per channel |
| mon_lds | input | 1 | Monitor select: 1 routes a strobe, 0 routes lock |
| mon_t1 | input | 1 | Monitor select: channel |
| mon_t2 | input | 1 | Monitor select: feedback instead of reference |
| pump_en | output | 2 | Pump drive enable (0 = high impedance) |
| pump_val | output | 2 | Pump drive level when enabled |
| lock_out | output | 1 | Merged lock indicator |
| mon_out | output | 1 | Monitor output |

## Verification
Two functions can act on the same clock edge: the immediate lock drop and the completion of a comparison. Both happen when a locked channel receives its trailing strobe on exactly the edge where the open width reaches 2. The bench provokes this with a width-2 comparison on a locked channel. It then runs narrow comparisons and confirms that lock returns only on the third one, which shows the coinciding completion was discarded. A separate case holds a pulse open past the drop and confirms the lock falls before the pulse closes, and that this late completion then counts as good.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_LEAD = 2'd1,
        PD_LAG  = 2'd2,
        PD_HOLD = 2'd3
    } pd_state_t;

    typedef enum logic [1:0] {
        LK_OFF = 2'd0,
        LK_ACQ = 2'd1,
        LK_ON  = 2'd2
    } lk_state_t;

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lock_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             div_i,
    input  logic             pol_i,
    input  logic             psave_i,
    output logic             pump_en_o,
    output logic             pump_val_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             done_o,
    output logic [CNT_W-1:0] width_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pd_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PD_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        done_o  = 1'b0;
        width_o = '0;
        if (psave_i) begin
            st_n  = PD_HOLD;
            cnt_n = '0;
        end else begin
            unique case (st)
                PD_IDLE: begin
                    if (ref_i && div_i) begin
                        done_o = 1'b1;
                    end else if (ref_i) begin
                        st_n  = PD_LEAD;
                        cnt_n = CNT_ONE;
                    end else if (div_i) begin
                        st_n  = PD_LAG;
                        cnt_n = CNT_ONE;
                    end
                end
                PD_LEAD: begin
                    if (div_i) begin
                        st_n    = PD_IDLE;
                        done_o  = 1'b1;
                        width_o = cnt;
                        cnt_n   = '0;
                    end else if (cnt != CNT_MAX) begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                PD_LAG: begin
                    if (ref_i) begin
                        st_n    = PD_IDLE;
                        done_o  = 1'b1;
                        width_o = cnt;
                        cnt_n   = '0;
                    end else if (cnt != CNT_MAX) begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                PD_HOLD: begin
                    if (ref_i) begin
                        st_n = PD_IDLE;
                    end
                end
                default: st_n = PD_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o     = (st == PD_LEAD) || (st == PD_LAG);
        err_cnt_o  = cnt;
        pump_en_o  = busy_o && !psave_i;
        pump_val_o = pump_en_o && (pol_i ? (st == PD_LEAD) : (st == PD_LAG));
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import pfd_lock_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int UNLOCK_W = 2,
    parameter int LOCK_W   = 4,
    parameter int LOCK_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psave_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] err_cnt_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             locked_o
);

    localparam int GW = (LOCK_CNT < 3) ? 1 : $clog2(LOCK_CNT);
    localparam logic [GW-1:0]    GOOD_LAST = GW'(LOCK_CNT - 1);
    localparam logic [CNT_W-1:0] DROP_AT   = CNT_W'(UNLOCK_W);
    localparam logic [CNT_W-1:0] GOOD_MAX  = CNT_W'(LOCK_W);

    lk_state_t     st, st_n;
    logic [GW-1:0] good, good_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= LK_OFF;
            good <= '0;
        end else begin
            st   <= st_n;
            good <= good_n;
        end
    end

    always_comb begin
        st_n   = st;
        good_n = good;
        if (psave_i) begin
            st_n   = LK_OFF;
            good_n = '0;
        end else begin
            unique case (st)
                LK_OFF, LK_ACQ: begin
                    if (done_i) begin
                        if (width_i <= GOOD_MAX) begin
                            if (good == GOOD_LAST) begin
                                st_n   = LK_ON;
                                good_n = '0;
                            end else begin
                                st_n   = LK_ACQ;
                                good_n = good + 1'b1;
                            end
                        end else begin
                            st_n   = LK_OFF;
                            good_n = '0;
                        end
                    end
                end
                LK_ON: begin
                    if (busy_i && (err_cnt_i >= DROP_AT)) begin
                        st_n   = LK_OFF;
                        good_n = '0;
                    end
                end
                default: begin
                    st_n   = LK_OFF;
                    good_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        locked_o = (st == LK_ON);
    end

endmodule

// File: rtl/mon_mux.sv
module mon_mux (
    input  logic       lock_i,
    input  logic [1:0] fr_i,
    input  logic [1:0] fp_i,
    input  logic       lds_i,
    input  logic       t1_i,
    input  logic       t2_i,
    output logic       mon_o
);

    always_comb begin
        if (!lds_i) begin
            mon_o = lock_i;
        end else if (t2_i) begin
            mon_o = t1_i ? fp_i[1] : fp_i[0];
        end else begin
            mon_o = t1_i ? fr_i[1] : fr_i[0];
        end
    end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int CNT_W    = 6,
    parameter int UNLOCK_W = 2,
    parameter int LOCK_W   = 4,
    parameter int LOCK_CNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_pulse,
    input  logic [1:0] div_pulse,
    input  logic [1:0] pol,
    input  logic [1:0] psave,
    input  logic       mon_lds,
    input  logic       mon_t1,
    input  logic       mon_t2,
    output logic [1:0] pump_en,
    output logic [1:0] pump_val,
    output logic       lock_out,
    output logic       mon_out
);

    localparam int NCH = 2;

    logic [NCH-1:0]            ch_busy;
    logic [NCH-1:0]            ch_done;
    logic [NCH-1:0]            ch_locked;
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;
    logic [NCH-1:0][CNT_W-1:0] ch_width;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pfd_core #(
            .CNT_W (CNT_W)
        ) u_pfd (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_i      (ref_pulse[g]),
            .div_i      (div_pulse[g]),
            .pol_i      (pol[g]),
            .psave_i    (psave[g]),
            .pump_en_o  (pump_en[g]),
            .pump_val_o (pump_val[g]),
            .busy_o     (ch_busy[g]),
            .err_cnt_o  (ch_cnt[g]),
            .done_o     (ch_done[g]),
            .width_o    (ch_width[g])
        );

        lock_fsm #(
            .CNT_W    (CNT_W),
            .UNLOCK_W (UNLOCK_W),
            .LOCK_W   (LOCK_W),
            .LOCK_CNT (LOCK_CNT)
        ) u_lock (
            .clk       (clk),
            .rst_n     (rst_n),
            .psave_i   (psave[g]),
            .busy_i    (ch_busy[g]),
            .err_cnt_i (ch_cnt[g]),
            .done_i    (ch_done[g]),
            .width_i   (ch_width[g]),
            .locked_o  (ch_locked[g])
        );
    end

    always_comb begin
        lock_out = &(ch_locked | psave);
    end

    mon_mux u_mon (
        .lock_i (lock_out),
        .fr_i   (ref_pulse),
        .fp_i   (div_pulse),
        .lds_i  (mon_lds),
        .t1_i   (mon_t1),
        .t2_i   (mon_t2),
        .mon_o  (mon_out)
    );

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
    parameter int CNT_W    = 6,
    parameter int UNLOCK_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            ref_pulse,
    input logic [1:0]            div_pulse,
    input logic [1:0]            psave,
    input logic [1:0]            pump_en,
    input logic [1:0]            ch_locked,
    input logic [1:0]            ch_busy,
    input logic [1:0]            ch_done,
    input logic [1:0][CNT_W-1:0] ch_cnt
);

    localparam logic [CNT_W-1:0] DROP_AT = CNT_W'(UNLOCK_W);

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R10
        psave_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            psave[g] |-> !pump_en[g]);

        // R11
        restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(psave[g]) |-> !pump_en[g]);

        // R6
        fast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_locked[g] && ch_busy[g] && (ch_cnt[g] >= DROP_AT)) |=> !ch_locked[g]);

        // R5
        lock_needs_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_locked[g]) |-> $past(ch_done[g]));

        // R2
        pump_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pump_en[g]) |-> $past(ref_pulse[g] | div_pulse[g]));
    end

endmodule

bind pfd_lock_top pfd_lock_chk #(
    .CNT_W    (CNT_W),
    .UNLOCK_W (UNLOCK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .div_pulse (div_pulse),
    .psave     (psave),
    .pump_en   (pump_en),
    .ch_locked (ch_locked),
    .ch_busy   (ch_busy),
    .ch_done   (ch_done),
    .ch_cnt    (ch_cnt)
);

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_p = '0;
    logic [1:0] div_p = '0;
    logic [1:0] pol = 2'b11;
    logic [1:0] psave = '0;
    logic       lds = 1'b0, t1 = 1'b0, t2 = 1'b0;
    logic [1:0] pump_en, pump_val;
    logic       lock_out, mon_out;

    always #5 clk = ~clk;

    pfd_lock_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_p),
        .div_pulse (div_p),
        .pol       (pol),
        .psave     (psave),
        .mon_lds   (lds),
        .mon_t1    (t1),
        .mon_t2    (t2),
        .pump_en   (pump_en),
        .pump_val  (pump_val),
        .lock_out  (lock_out),
        .mon_out   (mon_out)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    run_cmp = 1'b0;
    bit    finished = 1'b0;

    // behavioural model: st 0 idle, 1 ref leads, 2 ref lags, 3 hold
    int m_st[2], m_cnt[2], m_lk[2], m_good[2];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_st[c] = 0; m_cnt[c] = 0; m_lk[c] = 0; m_good[c] = 0;
            end else begin
                int  st, cnt, width;
                bit  r, d, busy, done;
                st = m_st[c]; cnt = m_cnt[c];
                r = ref_p[c]; d = div_p[c];
                busy = (st == 1) || (st == 2);
                done = 1'b0; width = 0;
                if (st == 0 && r && d) done = 1'b1;
                if (st == 1 && d) begin done = 1'b1; width = cnt; end
                if (st == 2 && r) begin done = 1'b1; width = cnt; end
                if (psave[c]) begin
                    m_lk[c] = 0; m_good[c] = 0;
                end else if (m_lk[c] != 0) begin
                    if (busy && cnt >= 2) begin m_lk[c] = 0; m_good[c] = 0; end
                end else if (done) begin
                    if (width <= 4) begin
                        m_good[c]++;
                        if (m_good[c] == 3) begin m_lk[c] = 1; m_good[c] = 0; end
                    end else m_good[c] = 0;
                end
                if (psave[c]) begin
                    st = 3; cnt = 0;
                end else if (st == 0) begin
                    if (r && !d) begin st = 1; cnt = 1; end
                    else if (d && !r) begin st = 2; cnt = 1; end
                end else if (st == 1) begin
                    if (d) begin st = 0; cnt = 0; end else if (cnt < 63) cnt++;
                end else if (st == 2) begin
                    if (r) begin st = 0; cnt = 0; end else if (cnt < 63) cnt++;
                end else if (r) begin
                    st = 0;
                end
                m_st[c] = st; m_cnt[c] = cnt;
            end
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b", cur_req, what, act, exp);
        end
    endtask

    function automatic logic exp_lock();
        return ((m_lk[0] != 0) || psave[0]) && ((m_lk[1] != 0) || psave[1]);
    endfunction

    always @(negedge clk) begin
        if (run_cmp) begin
            logic le, me;
            le = exp_lock();
            if (!lds) me = le;
            else if (t2) me = t1 ? div_p[1] : div_p[0];
            else me = t1 ? ref_p[1] : ref_p[0];
            for (int c = 0; c < 2; c++) begin
                logic ee, ve;
                ee = !psave[c] && (m_st[c] == 1 || m_st[c] == 2);
                ve = ee && (pol[c] ? (m_st[c] == 1) : (m_st[c] == 2));
                chk($sformatf("model pump_en[%0d]", c), pump_en[c], ee);
                chk($sformatf("model pump_val[%0d]", c), pump_val[c], ve);
            end
            chk("model lock_out", lock_out, le);
            chk("model mon_out", mon_out, me);
        end
    end

    task automatic step(logic [1:0] r, logic [1:0] d);
        @(negedge clk);
        #1;
        ref_p = r;
        div_p = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(2'b00, 2'b00);
    endtask

    task automatic probe_lock(logic exp);
        @(negedge clk);
        chk("lock_out", lock_out, exp);
        #1; ref_p = '0; div_p = '0;
    endtask

    task automatic probe_mon(logic exp);
        @(negedge clk);
        chk("mon_out", mon_out, exp);
        #1; ref_p = '0; div_p = '0;
    endtask

    task automatic probe_pump(int c, logic en, logic val);
        @(negedge clk);
        chk($sformatf("pump_en[%0d]", c), pump_en[c], en);
        chk($sformatf("pump_val[%0d]", c), pump_val[c], val);
        #1; ref_p = '0; div_p = '0;
    endtask

    // comparison of given width on channels in mask, reference leading
    task automatic cmp_w(logic [1:0] m, int w);
        if (w == 0) step(m, m);
        else begin
            step(m, 2'b00);
            idle(w - 1);
            step(2'b00, m);
        end
    endtask

    task automatic clear_ch0();
        psave[0] = 1'b1;
        idle(2);
        psave[0] = 1'b0;
        step(2'b01, 2'b00);
        idle(2);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("reset pump_en[0]", pump_en[0], 1'b0);
        chk("reset pump_en[1]", pump_en[1], 1'b0);
        chk("reset lock_out", lock_out, 1'b0);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;
        idle(2);
        psave = 2'b10;
        idle(2);

        cur_req = "R2";
        step(2'b01, 2'b00); probe_pump(0, 1'b1, 1'b1);
        step(2'b00, 2'b01); probe_pump(0, 1'b0, 1'b0);
        step(2'b00, 2'b01); probe_pump(0, 1'b1, 1'b0);
        step(2'b01, 2'b00); idle(2);

        cur_req = "R3";
        pol[0] = 1'b0;
        step(2'b01, 2'b00); probe_pump(0, 1'b1, 1'b0);
        step(2'b00, 2'b01);
        step(2'b00, 2'b01); probe_pump(0, 1'b1, 1'b1);
        step(2'b01, 2'b00); idle(2);
        pol[0] = 1'b1;

        cur_req = "R4";
        step(2'b01, 2'b01); probe_pump(0, 1'b0, 1'b0);
        step(2'b01, 2'b00); step(2'b01, 2'b00); probe_pump(0, 1'b1, 1'b1);
        step(2'b00, 2'b01); probe_pump(0, 1'b0, 1'b0);

        cur_req = "R5";
        clear_ch0();
        cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b1);

        cur_req = "R6";
        cmp_w(2'b01, 1); probe_lock(1'b1);
        step(2'b01, 2'b00); probe_lock(1'b1);
        step(2'b00, 2'b01); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b1);
        step(2'b01, 2'b00); probe_lock(1'b1); probe_lock(1'b1); probe_lock(1'b0);
        step(2'b00, 2'b01);
        cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b1);

        cur_req = "R5";
        clear_ch0();
        cmp_w(2'b01, 4); cmp_w(2'b01, 4); cmp_w(2'b01, 4); probe_lock(1'b1);

        cur_req = "R7";
        clear_ch0();
        cmp_w(2'b01, 1); cmp_w(2'b01, 1); cmp_w(2'b01, 5); probe_lock(1'b0);
        cmp_w(2'b01, 1); cmp_w(2'b01, 1); probe_lock(1'b0);
        cmp_w(2'b01, 1); probe_lock(1'b1);

        cur_req = "R8";
        psave[1] = 1'b0; probe_lock(1'b0);
        step(2'b10, 2'b00);
        cmp_w(2'b10, 1); cmp_w(2'b10, 0); probe_lock(1'b0);
        cmp_w(2'b10, 2); probe_lock(1'b1);
        psave[0] = 1'b1; probe_lock(1'b1);
        psave[0] = 1'b0; probe_lock(1'b0);
        psave = 2'b11; probe_lock(1'b1);
        psave = 2'b00;
        step(2'b11, 2'b00); idle(2);

        cur_req = "R9";
        lds = 1'b1; t1 = 1'b0; t2 = 1'b0; step(2'b01, 2'b00); probe_mon(1'b1);
        t1 = 1'b1; step(2'b01, 2'b00); probe_mon(1'b0);
        step(2'b10, 2'b00); probe_mon(1'b1);
        t1 = 1'b0; t2 = 1'b1; step(2'b00, 2'b01); probe_mon(1'b1);
        t1 = 1'b1; step(2'b00, 2'b01); probe_mon(1'b0);
        step(2'b00, 2'b10); probe_mon(1'b1);
        lds = 1'b0; t1 = 1'b0; t2 = 1'b0;
        idle(3);

        cur_req = "R10";
        clear_ch0();
        step(2'b01, 2'b00); probe_pump(0, 1'b1, 1'b1);
        psave[0] = 1'b1; probe_pump(0, 1'b0, 1'b0);
        idle(2);

        cur_req = "R11";
        psave[0] = 1'b0;
        step(2'b00, 2'b01); probe_pump(0, 1'b0, 1'b0);
        step(2'b01, 2'b00); probe_pump(0, 1'b0, 1'b0);
        step(2'b00, 2'b01); probe_pump(0, 1'b1, 1'b0);
        step(2'b01, 2'b00); idle(2);

        cur_req = "R2 R3 R5 R6 R7 R8 R9 R10 R11 mixed";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            ref_p = {($urandom % 4) == 0, ($urandom % 4) == 0};
            div_p = {($urandom % 4) == 0, ($urandom % 4) == 0};
            if (($urandom % 64) == 0) psave[$urandom % 2] ^= 1'b1;
            if (($urandom % 128) == 0) pol[$urandom % 2] ^= 1'b1;
            if (($urandom % 16) == 0) {lds, t1, t2} = 3'($urandom);
        end
        idle(2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule